// File: doc/BRIEF.md
# Folded-Clos Route Computation Unit

This block picks where a packet header goes next at one input of a 64-port folded-Clos router. A header carries a 16-bit destination node ID, the number of the input port it arrived on, two class flags (request and memory) and an adaptive-request flag. The unit first decides whether the destination sits in the sub-tree below this router. It does this by comparing the destination against a programmable root value, ignoring the bits a programmable mask covers.

Headers bound downward always route deterministically. A six-bit field taken from the destination at a configurable bit offset is a logical port, and a 64-entry table converts it into a physical port. The same logic therefore serves at any level of the hierarchy. Headers bound upward take one of two paths. A deterministic uplink comes from XOR-ing the input port with low destination bits, and memory traffic can optionally fold in further bits. Otherwise, when adaptive routing is requested and allowed, an eight-entry associative table supplies a 64-bit mask of feasible ports for a separate selector to choose from.

The result is registered. A small state register records what kind of result is on the outputs. The states are ST_IDLE (no result), ST_DOWN (down route), ST_UP_DET (deterministic up route) and ST_UP_ADPT (adaptive up mask). On every clock the state moves to ST_IDLE when no header is valid. Otherwise it moves to ST_DOWN if the destination is downstream, to ST_UP_ADPT if the header asks for adaptive routing, is not a request and hits a table entry, and to ST_UP_DET in all other cases.

Top module: `clos_route_unit`

## Requirements
- R1: After reset, res_valid, res_down and res_adaptive are 0, the remap table holds its identity mapping (entry i holds i), all up-table entries are invalid, and root, root mask, down shift and hash settings are 0.
- R2: A destination is downstream exactly when (dest & ~root_mask) == (root & ~root_mask). With root 0x0060 and mask 0x001F, destinations 96 to 127 route down and all other destinations route up. A downstream header always yields res_down=1 and res_adaptive=0, whatever its flags.
- R3: A down result has res_port = remap[(dest >> down_shift) & 63] and res_mask = 1 << res_port. down_shift sits in bits [3:0] of config address 0x02.
- R4: Writing address 0x40+i sets remap entry i to cfg_wdata[5:0].
- R5: A deterministic up result has res_port = up_base | ((in_port ^ dest[5:0]) & up_sel) and res_mask = 1 << res_port. up_sel is in bits [5:0] and up_base in bits [11:6] of config address 0x03. Root goes in bits [15:0] of address 0x00 and the root mask in bits [15:0] of address 0x01.
- R6: When fold_en (bit 12 of address 0x03) is 1 and the header is memory class, dest[11:6] is also XOR-ed into the hash. Otherwise it is not.
- R7: Request-class headers never produce an adaptive result, and neither do headers whose adaptive flag is 0.
- R8: An adaptive up header that matches valid up-table entries gets res_adaptive=1, res_port=0 and res_mask equal to the port mask of the lowest-index matching entry. Entry k matches when (dest & ~kmask) == (kval & ~kmask). Address 0x10+k writes kval in [15:0] and kmask in [31:16] and makes the entry valid. Address 0x18+k writes port mask bits [31:0] and address 0x20+k writes bits [63:32].
- R9: An adaptive up header that matches no valid entry falls back to the deterministic up result, with res_adaptive=0.
- R10: res_valid is 1 in exactly the cycle after a cycle with hdr_valid=1.
- R11: A configuration write takes effect for headers in later cycles. A header in the same cycle as the write sees the old setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_dest | input | 16 | Destination node ID |
| hdr_in_port | input | 6 | Input port number |
| hdr_is_req | input | 1 | Request class (ordered) |
| hdr_is_mem | input | 1 | Memory traffic (hash fold eligible) |
| hdr_adaptive | input | 1 | Header asks for adaptive up routing |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| res_valid | output | 1 | Result valid |
| res_down | output | 1 | Result is a down route |
| res_adaptive | output | 1 | Result is a feasible-port mask |
| res_port | output | 6 | Chosen physical port |
| res_mask | output | 64 | Feasible ports (one-hot if deterministic) |

## Verification
The assertions assume that reset is held for at least one clock and that hdr_valid and the flag inputs are never unknown while reset is released. They also assume that software leaves up_base bits clear wherever up_sel has bits set. This assumption does not affect correctness, but the bench's hash formula relies on it. The stimulus drives every input on the falling edge from tasks, always programs disjoint up_base and up_sel fields, and holds reset for several cycles before the first header. The sweeps cover every input port against every low destination value, and a 256-destination range around the downstream window.

// File: rtl/clos_route_pkg.sv
package clos_route_pkg;

    // Kind of result currently held on the outputs
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DOWN    = 2'd1,
        ST_UP_DET  = 2'd2,
        ST_UP_ADPT = 2'd3
    } route_state_e;

    // Configuration address map (7-bit address)
    localparam logic [6:0] CFG_ROOT     = 7'h00;
    localparam logic [6:0] CFG_RMASK    = 7'h01;
    localparam logic [6:0] CFG_DSHIFT   = 7'h02;
    localparam logic [6:0] CFG_HASH     = 7'h03;
    localparam logic [3:0] CFG_UPKEY_HI = 4'h2;   // 0x10..0x17 key, 0x18..0x1F lo ports
    localparam logic [3:0] CFG_UPHI_HI  = 4'h4;   // 0x20..0x27 hi ports

endpackage

// File: rtl/clos_subtree_detect.sv
module clos_subtree_detect #(
    parameter int DEST_W = 16
) (
    input  logic [DEST_W-1:0] dest,
    input  logic [DEST_W-1:0] root,
    input  logic [DEST_W-1:0] root_mask,
    output logic              is_down
);
    always_comb begin
        is_down = ((dest & ~root_mask) == (root & ~root_mask));
    end
endmodule

// File: rtl/clos_down_remap.sv
module clos_down_remap #(
    parameter int DEST_W = 16,
    parameter int PORT_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PORT_W-1:0]         wr_idx,
    input  logic [PORT_W-1:0]         wr_port,
    input  logic [DEST_W-1:0]         dest,
    input  logic [$clog2(DEST_W)-1:0] shift,
    output logic [PORT_W-1:0]         phys_port
);
    localparam int NENT = 1 << PORT_W;

    logic [PORT_W-1:0] table_q [NENT];
    logic [DEST_W-1:0] shifted;
    logic [PORT_W-1:0] logical;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) begin
                table_q[i] <= PORT_W'(i);
            end
        end else if (wr_en) begin
            table_q[wr_idx] <= wr_port;
        end
    end

    always_comb begin
        shifted   = dest >> shift;
        logical   = shifted[PORT_W-1:0];
        phys_port = table_q[logical];
    end
endmodule

// File: rtl/clos_up_hash.sv
module clos_up_hash #(
    parameter int DEST_W = 16,
    parameter int PORT_W = 6
) (
    input  logic [DEST_W-1:0] dest,
    input  logic [PORT_W-1:0] in_port,
    input  logic              fold,
    input  logic [PORT_W-1:0] up_sel,
    input  logic [PORT_W-1:0] up_base,
    output logic [PORT_W-1:0] up_port
);
    logic [PORT_W-1:0] extra;
    logic [PORT_W-1:0] mix;

    always_comb begin
        extra   = fold ? dest[2*PORT_W-1:PORT_W] : '0;
        mix     = in_port ^ dest[PORT_W-1:0] ^ extra;
        up_port = up_base | (mix & up_sel);
    end
endmodule

// File: rtl/clos_up_table.sv
module clos_up_table #(
    parameter int DEST_W = 16,
    parameter int NPORTS = 64,
    parameter int UP_ENT = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_key,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic [$clog2(UP_ENT)-1:0] wr_idx,
    input  logic [31:0]               wr_data,
    input  logic [DEST_W-1:0]         dest,
    output logic                      hit,
    output logic [NPORTS-1:0]         hit_mask
);
    logic [UP_ENT-1:0]  ent_valid;
    logic [UP_ENT-1:0]  ent_match;
    logic [DEST_W-1:0]  ent_val   [UP_ENT];
    logic [DEST_W-1:0]  ent_msk   [UP_ENT];
    logic [NPORTS-1:0]  ent_ports [UP_ENT];

    for (genvar k = 0; k < UP_ENT; k++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_valid[k] <= 1'b0;
                ent_val[k]   <= '0;
                ent_msk[k]   <= '0;
                ent_ports[k] <= '0;
            end else if (wr_idx == k) begin
                if (wr_key) begin
                    ent_valid[k] <= 1'b1;
                    ent_val[k]   <= wr_data[DEST_W-1:0];
                    ent_msk[k]   <= wr_data[16 +: DEST_W];
                end
                if (wr_lo) ent_ports[k][31:0] <= wr_data;
                if (wr_hi) ent_ports[k][NPORTS-1:32] <= wr_data[NPORTS-33:0];
            end
        end
        assign ent_match[k] = ent_valid[k] &&
            ((dest & ~ent_msk[k]) == (ent_val[k] & ~ent_msk[k]));
    end

    // Lowest index wins
    always_comb begin
        hit      = 1'b0;
        hit_mask = '0;
        for (int k = UP_ENT - 1; k >= 0; k--) begin
            if (ent_match[k]) begin
                hit      = 1'b1;
                hit_mask = ent_ports[k];
            end
        end
    end

    AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (ent_valid != '0)); // R8
endmodule

// File: rtl/clos_route_unit.sv
module clos_route_unit
    import clos_route_pkg::*;
#(
    parameter int DEST_W = 16,
    parameter int PORT_W = 6,
    parameter int UP_ENT = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_valid,
    input  logic [15:0]            hdr_dest,
    input  logic [5:0]             hdr_in_port,
    input  logic                   hdr_is_req,
    input  logic                   hdr_is_mem,
    input  logic                   hdr_adaptive,
    input  logic                   cfg_we,
    input  logic [6:0]             cfg_addr,
    input  logic [31:0]            cfg_wdata,
    output logic                   res_valid,
    output logic                   res_down,
    output logic                   res_adaptive,
    output logic [5:0]             res_port,
    output logic [63:0]            res_mask
);
    localparam int NPORTS  = 1 << PORT_W;
    localparam int SHIFT_W = $clog2(DEST_W);
    localparam int UIDX_W  = $clog2(UP_ENT);

    // Configuration registers
    logic [DEST_W-1:0]  root_q, rmask_q;
    logic [SHIFT_W-1:0] dshift_q;
    logic [PORT_W-1:0]  up_sel_q, up_base_q;
    logic               fold_en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q    <= '0;
            rmask_q   <= '0;
            dshift_q  <= '0;
            up_sel_q  <= '0;
            up_base_q <= '0;
            fold_en_q <= 1'b0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_ROOT:   root_q   <= cfg_wdata[DEST_W-1:0];
                CFG_RMASK:  rmask_q  <= cfg_wdata[DEST_W-1:0];
                CFG_DSHIFT: dshift_q <= cfg_wdata[SHIFT_W-1:0];
                CFG_HASH: begin
                    up_sel_q  <= cfg_wdata[PORT_W-1:0];
                    up_base_q <= cfg_wdata[2*PORT_W-1:PORT_W];
                    fold_en_q <= cfg_wdata[2*PORT_W];
                end
                default: ;
            endcase
        end
    end

    // Decoded table writes
    logic remap_we, key_we, lo_we, hi_we;
    always_comb begin
        remap_we = cfg_we && cfg_addr[6];
        key_we   = cfg_we && (cfg_addr[6:3] == CFG_UPKEY_HI);
        lo_we    = cfg_we && (cfg_addr[6:3] == (CFG_UPKEY_HI + 4'h1));
        hi_we    = cfg_we && (cfg_addr[6:3] == CFG_UPHI_HI);
    end

    // Route datapath
    logic              is_down;
    logic [PORT_W-1:0] down_port;
    logic [PORT_W-1:0] up_port;
    logic              tbl_hit;
    logic [NPORTS-1:0] tbl_mask;

    clos_subtree_detect #(.DEST_W(DEST_W)) u_detect (
        .dest      (hdr_dest),
        .root      (root_q),
        .root_mask (rmask_q),
        .is_down   (is_down)
    );

    clos_down_remap #(.DEST_W(DEST_W), .PORT_W(PORT_W)) u_remap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (remap_we),
        .wr_idx    (cfg_addr[PORT_W-1:0]),
        .wr_port   (cfg_wdata[PORT_W-1:0]),
        .dest      (hdr_dest),
        .shift     (dshift_q),
        .phys_port (down_port)
    );

    clos_up_hash #(.DEST_W(DEST_W), .PORT_W(PORT_W)) u_hash (
        .dest    (hdr_dest),
        .in_port (hdr_in_port),
        .fold    (fold_en_q && hdr_is_mem),
        .up_sel  (up_sel_q),
        .up_base (up_base_q),
        .up_port (up_port)
    );

    clos_up_table #(.DEST_W(DEST_W), .NPORTS(NPORTS), .UP_ENT(UP_ENT)) u_uptbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_key   (key_we),
        .wr_lo    (lo_we),
        .wr_hi    (hi_we),
        .wr_idx   (cfg_addr[UIDX_W-1:0]),
        .wr_data  (cfg_wdata),
        .dest     (hdr_dest),
        .hit      (tbl_hit),
        .hit_mask (tbl_mask)
    );

    // State register and next-state / next-result logic
    route_state_e      state_q, state_d;
    logic [PORT_W-1:0] port_q, port_d;
    logic [NPORTS-1:0] mask_q, mask_d;

    always_comb begin
        state_d = ST_IDLE;
        port_d  = port_q;
        mask_d  = mask_q;
        if (hdr_valid) begin
            if (is_down) begin
                state_d = ST_DOWN;
                port_d  = down_port;
                mask_d  = NPORTS'(1) << down_port;
            end else if (hdr_adaptive && !hdr_is_req && tbl_hit) begin
                state_d = ST_UP_ADPT;
                port_d  = '0;
                mask_d  = tbl_mask;
            end else begin
                state_d = ST_UP_DET;
                port_d  = up_port;
                mask_d  = NPORTS'(1) << up_port;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            port_q  <= port_d;
            mask_q  <= mask_d;
        end
    end

    // Output decode
    always_comb begin
        res_valid    = 1'b0;
        res_down     = 1'b0;
        res_adaptive = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_DOWN:    begin res_valid = 1'b1; res_down = 1'b1; end
            ST_UP_DET:  res_valid = 1'b1;
            ST_UP_ADPT: begin res_valid = 1'b1; res_adaptive = 1'b1; end
            default:    ;
        endcase
        res_port = port_q;
        res_mask = mask_q;
    end

    // Assertions
    AST_VALID_FOLLOWS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> res_valid); // R10
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !res_valid); // R10
    AST_REQ_NEVER_ADAPTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && (hdr_is_req || !hdr_adaptive)) |=> !res_adaptive); // R7
    AST_DOWN_IS_DETERMINISTIC: assert property (@(posedge clk) disable iff (!rst_n)
        res_down |-> !res_adaptive); // R2
    AST_DET_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_adaptive) |-> ($countones(res_mask) == 1)); // R3
    AST_DET_MASK_MATCHES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_adaptive) |-> res_mask[res_port]); // R5
endmodule

// File: tb/clos_route_unit_test.sv
module clos_route_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_valid = 1'b0;
    logic [15:0] hdr_dest = '0;
    logic [5:0]  hdr_in_port = '0;
    logic        hdr_is_req = 1'b0;
    logic        hdr_is_mem = 1'b0;
    logic        hdr_adaptive = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        res_valid, res_down, res_adaptive;
    logic [5:0]  res_port;
    logic [63:0] res_mask;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Bench copy of software-visible settings
    logic [15:0] m_root = 16'h0060, m_rmask = 16'h001F;
    logic [5:0]  m_sel = 6'h07, m_base = 6'h20;

    always #2 clk = ~clk;

    clos_route_unit uut (
        .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_dest(hdr_dest),
        .hdr_in_port(hdr_in_port), .hdr_is_req(hdr_is_req), .hdr_is_mem(hdr_is_mem),
        .hdr_adaptive(hdr_adaptive), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .res_valid(res_valid), .res_down(res_down),
        .res_adaptive(res_adaptive), .res_port(res_port), .res_mask(res_mask)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [6:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic hdr(input logic [15:0] d, input logic [5:0] p,
                       input bit req, input bit mem, input bit adp);
        hdr_valid = 1'b1; hdr_dest = d; hdr_in_port = p;
        hdr_is_req = req; hdr_is_mem = mem; hdr_adaptive = adp;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic idle();
        hdr_valid = 1'b0;
        @(posedge clk); @(negedge clk);
    endtask

    function automatic bit f_down(input logic [15:0] d);
        return (d & ~m_rmask) == (m_root & ~m_rmask);
    endfunction

    function automatic logic [5:0] f_up(input logic [15:0] d, input logic [5:0] p,
                                        input bit fold);
        logic [5:0] x;
        x = p ^ d[5:0] ^ (fold ? d[11:6] : 6'd0);
        return m_base | (x & m_sel);
    endfunction

    // Check a deterministic up result
    task automatic chk_up(input string req, input logic [15:0] d, input logic [5:0] p,
                          input bit fold);
        logic [5:0] e;
        e = f_up(d, p, fold);
        chk(req, {61'd0, res_valid, res_down, res_adaptive}, 64'b100);
        chk(req, 64'(res_port), 64'(e));
        chk(req, res_mask, 64'd1 << e);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 valid", 64'(res_valid), 64'd0);
        chk("R1 down", 64'(res_down), 64'd0);
        chk("R1 adaptive", 64'(res_adaptive), 64'd0);
        // R1: root 0 / mask 0 -> only dest 0 is downstream, identity remap
        hdr(16'h0000, 6'd0, 1, 0, 0);
        chk("R1 dest0 down", 64'(res_down), 64'd1);
        chk("R1 identity port", 64'(res_port), 64'd0);
        hdr(16'h0005, 6'd0, 1, 0, 0);
        chk("R1 up port zero hash", 64'(res_port), 64'd0);
        chk("R1 up not down", 64'(res_down), 64'd0);

        cfg(7'h00, 32'h0060);
        cfg(7'h01, 32'h001F);
        cfg(7'h03, {19'd0, 1'b0, m_base, m_sel});

        // R2 / R4 identity / R5: sweep destinations 0..255
        for (int d = 0; d < 256; d++) begin
            hdr(16'(d), 6'd0, 1, 0, 0);
            chk("R2 direction", 64'(res_down), 64'(d >= 96 && d <= 127));
            if (f_down(16'(d))) begin
                chk("R4 identity remap", 64'(res_port), 64'(d & 63));
                chk("R3 mask", res_mask, 64'd1 << (d & 63));
            end else begin
                chk_up("R5 up sweep", 16'(d), 6'd0, 0);
            end
        end
        // R2: downstream ignores adaptive flag
        hdr(16'h0070, 6'd3, 0, 0, 1);
        chk("R2 down not adaptive", {62'd0, res_down, res_adaptive}, 64'b10);

        // R4: program reversed remap
        for (int i = 0; i < 64; i++) cfg(7'(64 + i), 32'(63 - i));
        for (int d = 96; d < 128; d++) begin
            hdr(16'(d), 6'd5, 1, 0, 0);
            chk("R4 remap", 64'(res_port), 64'(63 - (d & 63)));
        end
        // R3: down shift 1
        cfg(7'h02, 32'd1);
        for (int d = 96; d < 128; d++) begin
            hdr(16'(d), 6'd0, 1, 0, 0);
            chk("R3 shift", 64'(res_port), 64'(63 - ((d >> 1) & 63)));
            chk("R3 onehot", res_mask, 64'd1 << (63 - ((d >> 1) & 63)));
        end
        cfg(7'h02, 32'd0);

        // R5: every input port against every low destination
        for (int p = 0; p < 64; p++) begin
            for (int d = 0; d < 64; d++) begin
                hdr(16'(d), 6'(p), 1, 0, 0);
                chk_up("R5 hash", 16'(d), 6'(p), 0);
            end
        end

        // R6: folding of upper bits for memory traffic
        for (int k = 0; k < 64; k++) begin
            hdr(16'((k << 6) | 9), 6'd2, 1, 1, 0);
            chk_up("R6 no fold when disabled", 16'((k << 6) | 9), 6'd2, 0);
        end
        cfg(7'h03, {19'd0, 1'b1, m_base, m_sel});
        for (int k = 0; k < 64; k++) begin
            hdr(16'((k << 6) | 9), 6'd2, 1, 1, 0);
            chk_up("R6 fold memory", 16'((k << 6) | 9), 6'd2, 1);
            hdr(16'((k << 6) | 9), 6'd2, 1, 0, 0);
            chk_up("R6 no fold non-memory", 16'((k << 6) | 9), 6'd2, 0);
        end
        cfg(7'h03, {19'd0, 1'b0, m_base, m_sel});

        // R8: up-table entries 2 and 5
        cfg(7'h12, {16'h00FF, 16'h0100});
        cfg(7'h1A, 32'h0000_FF00);
        cfg(7'h22, 32'h0000_0001);
        cfg(7'h15, {16'h0FFF, 16'h0000});
        cfg(7'h1D, 32'h0000_0000);
        cfg(7'h25, 32'hF000_0000);
        hdr(16'h0150, 6'd1, 0, 0, 1);
        chk("R8 priority adaptive", 64'(res_adaptive), 64'd1);
        chk("R8 priority mask", res_mask, 64'h0000_0001_0000_FF00);
        chk("R8 port zero", 64'(res_port), 64'd0);
        hdr(16'h0250, 6'd1, 0, 0, 1);
        chk("R8 second entry mask", res_mask, 64'hF000_0000_0000_0000);
        // R7: request class or no adaptive flag stays deterministic
        hdr(16'h0150, 6'd1, 1, 0, 1);
        chk_up("R7 request deterministic", 16'h0150, 6'd1, 0);
        hdr(16'h0150, 6'd1, 0, 0, 0);
        chk_up("R7 flag clear deterministic", 16'h0150, 6'd1, 0);
        // R9: no match falls back
        hdr(16'h2000, 6'd4, 0, 0, 1);
        chk_up("R9 fallback", 16'h2000, 6'd4, 0);

        // R11: write in the same cycle as a header
        cfg_we = 1'b1; cfg_addr = 7'(64 + 40); cfg_wdata = 32'd5;
        hdr(16'd104, 6'd0, 1, 0, 0);
        cfg_we = 1'b0;
        chk("R11 old value same cycle", 64'(res_port), 64'd23);
        hdr(16'd104, 6'd0, 1, 0, 0);
        chk("R11 new value next header", 64'(res_port), 64'd5);

        // R10: valid drops one cycle after header stops
        idle();
        chk("R10 no header no valid", 64'(res_valid), 64'd0);
        idle();
        chk("R10 stays idle", 64'(res_valid), 64'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule